// File: doc/BRIEF.md
# Start/stop framed serial link transmitter

This block turns a stream of parallel payload words into a serial bit stream for a link whose latency must never vary. Every symbol on the line is a start bit, the payload word sent unmodified with its most significant bit first, and then a stop bit. No line code or scrambling is applied, so the delay from the moment a word is sampled to the moment its first bit leaves is a fixed number of cycles, both after reset and after any resynchronisation.

A single clock drives the block, and a bit-enable marks the clock cycles on which the line advances by one bit. The input word is sampled once per symbol, on the bit-enabled cycle that ends the previous symbol's stop bit. At that same instant the sync request is sampled. When the request is high, the symbol carries an alignment payload in place of the user word. This payload has its upper half all ones and its lower half all zeros, and it gives a receiver an unambiguous pattern to lock onto. A user word that is offered while sync is requested is discarded, and a saturating counter records it. A strobe marks the first clock of every start bit.

Top module: `sslink_tx`

## Requirements
- R1: Each symbol is PAYLOAD_W+2 bit periods long: a start bit of 1, the payload MSB first, then a stop bit of 0. A 0 therefore always precedes each start bit.
- R2: When sync_req is 0 and word_valid is 1 at the sampling instant, the payload is word_data exactly as given.
- R3: When sync_req is 1 at the sampling instant, the payload is the alignment pattern: the upper PAYLOAD_W/2 bits are 1 and the lower PAYLOAD_W/2 bits are 0. Held requests give back-to-back alignment symbols.
- R4: When both sync_req and word_valid are 0 at the sampling instant, the payload is all zeros.
- R5: drop_count rises by exactly one for each sampling instant that has both sync_req and word_valid at 1. It changes only in the first clock of a start bit, and it saturates at all ones.
- R6: sym_strobe is high for exactly one clock, the first clock in which a start bit is on ser_out, and at no other time.
- R7: The first symbol is loaded on the first bit-enabled cycle after reset. After that, a new symbol starts every PAYLOAD_W+2 bit-enabled cycles, regardless of content or resync.
- R8: During reset, ser_out is 0, sym_strobe is 0 and drop_count is 0.
- R9: A cycle with bit_en low leaves ser_out and drop_count unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advances the line by one bit on this cycle |
| word_valid | input | 1 | word_data holds a user word |
| word_data | input | PAYLOAD_W | User payload word |
| sync_req | input | 1 | Send the alignment payload instead of user data |
| ser_out | output | 1 | Serial line bit |
| sym_strobe | output | 1 | First clock of each start bit |
| drop_count | output | CNT_W | Saturating count of discarded user words |

## Verification
The bench builds the block with the default 18-bit payload and a 3-bit drop counter. With the narrow counter, saturation is reached within a few dozen symbols. Sixty symbols are swept: walking-one and walking-zero words, then mixed words, with valid and sync combinations that include a run of consecutive sync symbols. The bit-enable runs at full rate, then every second cycle, then every third cycle. Under all three rates the bench checks the symbol spacing, the hold behaviour while the bit-enable is low, and the exact bit content of every symbol.

// File: rtl/sslink_pkg.sv
package sslink_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_DATA,
        SRC_SYNC,
        SRC_SYNC_DROP
    } src_e;
endpackage

// File: rtl/sslink_src_sel.sv
module sslink_src_sel
    import sslink_pkg::*;
#(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 word_valid,
    input  logic [PAYLOAD_W-1:0] word_data,
    input  logic                 sync_req,
    output logic [PAYLOAD_W-1:0] payload,
    output src_e                 src
);
    localparam int HALF = PAYLOAD_W / 2;

    logic [PAYLOAD_W-1:0] sync_pat;

    // alignment pattern: upper half ones, lower half zeros
    for (genvar g = 0; g < PAYLOAD_W; g++) begin : g_sync
        assign sync_pat[g] = (g >= HALF);
    end

    always_comb begin
        if (sync_req) begin
            payload = sync_pat;
            src     = word_valid ? SRC_SYNC_DROP : SRC_SYNC;
        end else if (word_valid) begin
            payload = word_data;
            src     = SRC_DATA;
        end else begin
            payload = '0;
            src     = SRC_IDLE;
        end
    end
endmodule

// File: rtl/sslink_shifter.sv
module sslink_shifter #(
    parameter int PAYLOAD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 load,
    output logic                 ser_out,
    output logic                 sym_strobe
);
    localparam int SYM_W = PAYLOAD_W + 2;
    localparam int BW    = $clog2(SYM_W);
    localparam logic [BW-1:0] LAST = BW'(SYM_W - 1);

    typedef struct packed {
        logic [SYM_W-1:0] shreg;
        logic [BW-1:0]    bitpos;
        logic             strobe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        load        = bit_en && (st_q.bitpos == LAST);
        if (load) begin
            st_d.shreg  = {1'b1, payload, 1'b0};
            st_d.bitpos = '0;
            st_d.strobe = 1'b1;
        end else if (bit_en) begin
            st_d.shreg  = {st_q.shreg[SYM_W-2:0], 1'b0};
            st_d.bitpos = st_q.bitpos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg  <= '0;
            st_q.bitpos <= LAST;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out    = st_q.shreg[SYM_W-1];
    assign sym_strobe = st_q.strobe;
endmodule

// File: rtl/sslink_drop_cnt.sv
module sslink_drop_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc && (count_q != '1)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/sslink_tx.sv
module sslink_tx
    import sslink_pkg::*;
#(
    parameter int PAYLOAD_W = 18,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 word_valid,
    input  logic [PAYLOAD_W-1:0] word_data,
    input  logic                 sync_req,
    output logic                 ser_out,
    output logic                 sym_strobe,
    output logic [CNT_W-1:0]     drop_count
);
    logic [PAYLOAD_W-1:0] payload;
    src_e                 src;
    logic                 load;

    sslink_src_sel #(.PAYLOAD_W(PAYLOAD_W)) i_sel (
        .word_valid (word_valid),
        .word_data  (word_data),
        .sync_req   (sync_req),
        .payload    (payload),
        .src        (src)
    );

    sslink_shifter #(.PAYLOAD_W(PAYLOAD_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .payload    (payload),
        .load       (load),
        .ser_out    (ser_out),
        .sym_strobe (sym_strobe)
    );

    sslink_drop_cnt #(.CNT_W(CNT_W)) i_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (load && (src == SRC_SYNC_DROP)),
        .count (drop_count)
    );
endmodule

// File: rtl/sslink_tx_chk.sv
module sslink_tx_chk #(
    parameter int PAYLOAD_W = 18,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             ser_out,
    input logic             sym_strobe,
    input logic [CNT_W-1:0] drop_count
);
    localparam int SYM_W = PAYLOAD_W + 2;
    localparam int PW    = $clog2(SYM_W + 2);

    logic [PW-1:0] since_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (sym_strobe) begin
            since_q <= PW'(bit_en);
            seen_q  <= 1'b1;
        end else if (bit_en && (since_q != '1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_STROBE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> ser_out);                                        // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |=> !sym_strobe);                                    // R6
    AST_ZERO_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> !$past(ser_out));                                // R1
    AST_SYMBOL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_strobe && seen_q) |-> (since_q == PW'(SYM_W)));            // R7
    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));                                  // R9
    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(drop_count));                               // R9
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
            (drop_count == $past(drop_count) + 1'b1));                  // R5
    AST_DROP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> sym_strobe);              // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> (!ser_out && !sym_strobe && drop_count == '0)); // R8
endmodule

bind sslink_tx sslink_tx_chk #(.PAYLOAD_W(PAYLOAD_W), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .ser_out    (ser_out),
    .sym_strobe (sym_strobe),
    .drop_count (drop_count)
);

// File: tb/test_sslink_tx.sv
module test_sslink_tx;
    localparam int PW         = 18;
    localparam int CW         = 3;
    localparam int SW         = PW + 2;
    localparam int NF         = 60;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          word_valid = 1'b0;
    logic [PW-1:0] word_data = '0;
    logic          sync_req = 1'b0;
    logic          ser_out;
    logic          sym_strobe;
    logic [CW-1:0] drop_count;

    int checks = 0;
    int errors = 0;

    sslink_tx #(.PAYLOAD_W(PW), .CNT_W(CW)) i_sslink_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .word_valid (word_valid),
        .word_data  (word_data),
        .sync_req   (sync_req),
        .ser_out    (ser_out),
        .sym_strobe (sym_strobe),
        .drop_count (drop_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // stimulus for symbol k: {valid, sync, data}
    function automatic logic [PW+1:0] stim(int k);
        logic [PW-1:0] d;
        logic v, s;
        if (k >= NF) return '0;
        if (k < PW)          d = PW'(1) << k;
        else if (k < 2 * PW) d = ~(PW'(1) << (k - PW));
        else                 d = PW'(k * 32'h0002B5C3 + 32'h15A5A);
        v = (k % 5) != 3;
        s = ((k % 7) == 2) || ((k / 10) == 4);
        return {v, s, d};
    endfunction

    function automatic logic [SW-1:0] expect_sym(logic [PW+1:0] st);
        logic [PW-1:0] pay;
        if (st[PW])          pay = PW'(((1 << (PW / 2)) - 1) << (PW / 2));
        else if (st[PW+1])   pay = st[PW-1:0];
        else                 pay = '0;
        return {1'b1, pay, 1'b0};
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [PW+1:0] st);
        word_valid = st[PW+1];
        sync_req   = st[PW];
        word_data  = st[PW-1:0];
    endtask

    initial begin
        logic [PW+1:0] pend, cur;
        logic [SW-1:0] got;
        int cyc, k, idx, frames, per, exp_drop, mode;
        bit be, prev_be, prev_ser, collecting, first;
        cyc = 0; k = 0; idx = 0; frames = 0; per = 0; exp_drop = 0;
        be = 0; prev_be = 0; prev_ser = 0; collecting = 0; first = 1;
        got = '0;
        pend = stim(0);
        cur  = '0;
        apply(pend);
        repeat (3) @(negedge clk);
        // R8: reset state
        check(ser_out == 1'b0, "R8 ser_out", ser_out, 0);
        check(sym_strobe == 1'b0, "R8 strobe", sym_strobe, 0);
        check(drop_count == '0, "R8 drop_count", drop_count, 0);
        rst_n = 1'b1;
        while (frames < NF && cyc < WATCHDOG) begin
            @(negedge clk);
            cyc++;
            mode   = (k / 20) % 3;
            be     = (mode == 0) ? 1'b1 : ((cyc % (mode + 1)) == 0);
            bit_en = be;
            if (cyc > 1 && !prev_be) begin
                check(ser_out == prev_ser, "R9 hold", ser_out, prev_ser);
            end
            if (sym_strobe) begin
                // R7: symbol spacing in bit-enabled cycles
                check(per == (first ? 1 : SW), "R7 spacing", per, first ? 1 : SW);
                check(!collecting, "R6 strobe mid-symbol", collecting, 0);
                first = 0;
                per   = 0;
                cur   = pend;
                if (cur[PW+1] && cur[PW] && exp_drop < (1 << CW) - 1) exp_drop++;
                check(drop_count == CW'(exp_drop), "R5 drop_count", drop_count, exp_drop);
                k++;
                pend = stim(k);
                apply(pend);
                idx = 0;
                collecting = 1;
            end
            if (be) begin
                per++;
                if (collecting) begin
                    got = {got[SW-2:0], ser_out};
                    idx++;
                    if (idx == SW) begin
                        check(got == expect_sym(cur),
                              cur[PW] ? "R3 sync symbol" :
                              (cur[PW+1] ? "R1 R2 data symbol" : "R4 idle symbol"),
                              got, expect_sym(cur));
                        frames++;
                        collecting = 0;
                    end
                end
            end
            prev_be  = be;
            prev_ser = ser_out;
        end
        check(frames == NF, "R7 watchdog", frames, NF);
        check(drop_count == '1, "R5 saturation", drop_count, (1 << CW) - 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule